// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer

This block drives the reset lines of a processor subsystem that is split into several reset domains. These domains are:

- the security block;
- the reset controller core;
- the system-wide cold domain;
- a set of individually maskable warm-reset modules;
- the debug domain;
- the test-access-port (TAP) domain;
- a set of RAM-clear commands, one per on-chip memory.

When power-on reset is released, only the security domain comes out of reset. The rest of the subsystem waits until the fuse-checking logic reports that the fuses are valid. The controller then runs one cold reset over every domain except security, and after that it serves requests.

Requests for cold, warm, debug and TAP reset can come from outside or from software. The programmable fabric can also request a reset, which acts as a warm reset. The fabric request is honoured only once the fabric reports that it is configured.

Every assertion that the controller makes lasts a fixed number of clock cycles. Each output leaves the block through a two-flop stage. Power-on reset drives the outputs asynchronously, while release is always synchronous to the clock. A small register file holds the following:

- the warm-reset mask, one bit per module;
- the per-memory enable bits for clearing on cold reset;
- the per-memory enable bits for clearing on warm reset;
- a one-hot record of the cause of the last reset.

Top module: `reset_sequencer`

## Requirements
- R1: While porN is low, secRst, coreRst, coldRst, dbgRst, tapRst and every warmRst bit are high and every ramClr bit is low. The registers return to their defaults: mask 0, cold-clear enables all ones, warm-clear enables 0, and cause register 0x01.
- R2: After porN rises, secRst falls within 3 clock cycles. coreRst, coldRst, dbgRst, tapRst and warmRst stay high for as long as fuseValid stays low.
- R3: When fuseValid is sampled high, coreRst falls 2 cycles later. coldRst, dbgRst, tapRst and all warmRst bits are held for HOLD_CYCLES more cycles after that. Each ramClr[j] whose cold enable is set pulses for HOLD_CYCLES. secRst is never asserted again.
- R4: A coldReq seen while idle asserts coldRst, dbgRst, tapRst, all warmRst bits and the cold-enabled ramClr bits, and never secRst or coreRst. A coldReq seen during a warm, debug or TAP hold aborts that hold and starts a cold hold. coldReq takes priority over every other request.
- R5: A warm request asserts only warmRst bits and ramClr bits. It never asserts secRst, coreRst, coldRst, dbgRst or tapRst.
- R6: Setting bit i of the mask register (address 0) keeps warmRst[i] low during a warm reset. Bits 0 and 1, which belong to the security module and the processor core, cannot be masked. The register reads back what was written.
- R7: debugReq asserts only dbgRst. When debugReq and tapReq come together, the cause register records debug.
- R8: tapReq asserts only tapRst. tapRst is asserted only by a cold hold (R3, R4) or by tapReq.
- R9: fabricReq behaves as a warm request when fabricConfigured is high. When fabricConfigured is low, fabricReq changes no output and leaves the cause register unchanged.
- R10: The cold-clear enables are at address 1 and the warm-clear enables at address 2. Memory j belongs to warm module NUM_MODULES-NUM_RAMS+j. During a warm hold, ramClr[j] pulses only if its warm enable is set and its owning module is not masked.
- R11: Every domain assertion lasts exactly HOLD_CYCLES cycles at the output. Outputs change 2 cycles after the clock edge that samples the request. During a warm, debug or TAP hold, requests other than coldReq are ignored.
- R12: The cause register is at address 3, with bit 0 for power-on, bit 1 for cold, bit 2 for warm, bit 3 for debug, bit 4 for TAP and bit 5 for fabric. It holds the single bit of the most recent accepted request, and writing a 1 to a bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| fuseValid | input | 1 | Security block reports its fuses as loaded and valid |
| coldReq | input | 1 | Cold reset request |
| warmReq | input | 1 | Warm reset request |
| debugReq | input | 1 | Debug-domain reset request |
| tapReq | input | 1 | TAP-domain reset request |
| fabricReq | input | 1 | Reset request from programmable fabric |
| fabricConfigured | input | 1 | Fabric is configured; enables fabricReq |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| secRst | output | 1 | Security-domain reset |
| coreRst | output | 1 | Reset-controller core reset |
| coldRst | output | 1 | System cold-domain reset |
| warmRst | output | NUM_MODULES | Per-module warm resets |
| dbgRst | output | 1 | Debug-domain reset |
| tapRst | output | 1 | TAP-domain reset |
| ramClr | output | NUM_RAMS | Per-memory clear commands |

## Verification
The hardest situation to reach is a request that arrives in the middle of a hold that is already running. A cold request must abort a warm hold, while a debug request arriving during a warm hold must vanish without effect. The bench reaches both cases by pulsing a warm request, waiting a few cycles inside the hold, and then pulsing the second request. It then watches every output for the rest of the window.

Selective RAM clearing is brought out by loading a mask that hides some of the memory-owning modules together with warm-clear enables for all memories. The bench then checks that exactly the memories of the unmasked owners pulse.

// File: rtl/reset_sequencer_pkg.sv
package reset_sequencer_pkg;

  localparam int CAUSE_W = 6;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_COLD = 1;
  localparam int CAUSE_WARM = 2;
  localparam int CAUSE_DBG = 3;
  localparam int CAUSE_TAP = 4;
  localparam int CAUSE_FAB = 5;

  typedef enum logic [2:0] {
    ST_FUSE,
    ST_COLD,
    ST_IDLE,
    ST_WARM,
    ST_DBG
  } seqState_t;

  typedef struct packed {
    logic fuseWait;
    logic coldHold;
    logic warmHold;
    logic dbgHold;
    logic tapHold;
    logic causeLoad;
    logic [CAUSE_W-1:0] causeCode;
  } seqStrobe_t;

endpackage

// File: rtl/reset_sequencer_ctrl.sv
module reset_sequencer_ctrl
  import reset_sequencer_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       fuseValid,
  input  logic       coldReq,
  input  logic       warmReq,
  input  logic       debugReq,
  input  logic       tapReq,
  input  logic       fabricReq,
  input  logic       fabricConfigured,
  output seqStrobe_t strobe
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic dbgFlag, tapFlag;
  logic latchFlags;
  logic fabricEff;
  logic holdState;

  assign fabricEff = fabricReq & fabricConfigured;
  assign holdState = (state == ST_WARM) || (state == ST_DBG);

  always_comb begin
    nextState = state;
    latchFlags = 1'b0;
    strobe.causeLoad = 1'b0;
    strobe.causeCode = '0;
    case (state)
      ST_FUSE: begin
        if (fuseValid) nextState = ST_COLD;
      end
      ST_COLD: begin
        if (cnt == LAST) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (coldReq) begin
          nextState = ST_COLD;
          strobe.causeLoad = 1'b1;
          strobe.causeCode[CAUSE_COLD] = 1'b1;
        end else if (warmReq || fabricEff) begin
          nextState = ST_WARM;
          strobe.causeLoad = 1'b1;
          if (warmReq) strobe.causeCode[CAUSE_WARM] = 1'b1;
          else strobe.causeCode[CAUSE_FAB] = 1'b1;
        end else if (debugReq || tapReq) begin
          nextState = ST_DBG;
          latchFlags = 1'b1;
          strobe.causeLoad = 1'b1;
          if (debugReq) strobe.causeCode[CAUSE_DBG] = 1'b1;
          else strobe.causeCode[CAUSE_TAP] = 1'b1;
        end
      end
      ST_WARM, ST_DBG: begin
        if (coldReq) begin
          nextState = ST_COLD;
          strobe.causeLoad = 1'b1;
          strobe.causeCode[CAUSE_COLD] = 1'b1;
        end else if (cnt == LAST) begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= ST_FUSE;
      cnt <= '0;
      dbgFlag <= 1'b0;
      tapFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (latchFlags) begin
        dbgFlag <= debugReq;
        tapFlag <= tapReq;
      end
    end
  end

  assign strobe.fuseWait = (state == ST_FUSE);
  assign strobe.coldHold = (state == ST_COLD);
  assign strobe.warmHold = (state == ST_WARM);
  assign strobe.dbgHold = (state == ST_DBG) && dbgFlag;
  assign strobe.tapHold = (state == ST_DBG) && tapFlag;

  // R2: the core stays in its fuse wait until validation is reported
  p_fuse_gate_r2: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_FUSE && !fuseValid) |=> (state == ST_FUSE));

  // R9: an unconfigured fabric cannot leave the idle state
  p_fabric_gated_r9: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_IDLE && fabricReq && !fabricConfigured && !coldReq &&
     !warmReq && !debugReq && !tapReq) |=> (state == ST_IDLE));

  // R11: a hold is not cut short unless a cold request escalates it
  p_hold_min_r11: assert property (@(posedge clk) disable iff (!porN)
    ((holdState || state == ST_COLD) && cnt != LAST &&
     !(coldReq && holdState)) |=> (state == $past(state)));

endmodule

// File: rtl/reset_sequencer_datapath.sv
module reset_sequencer_datapath
  import reset_sequencer_pkg::*;
#(
  parameter int NUM_MODULES = 8,
  parameter int NUM_RAMS = 4,
  parameter int DATA_W = 32,
  parameter logic [NUM_MODULES-1:0] UNMASKABLE = {{(NUM_MODULES-2){1'b0}}, 2'b11}
) (
  input  logic                   clk,
  input  logic                   porN,
  input  seqStrobe_t             strobe,
  input  logic                   regWrEn,
  input  logic [1:0]             regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   secRst,
  output logic                   coreRst,
  output logic                   coldRst,
  output logic [NUM_MODULES-1:0] warmRst,
  output logic                   dbgRst,
  output logic                   tapRst,
  output logic [NUM_RAMS-1:0]    ramClr
);

  localparam int RAM_BASE = NUM_MODULES - NUM_RAMS;
  localparam int NUM_OUT = 5 + NUM_MODULES + NUM_RAMS;
  localparam int IDX_RAM = 0;
  localparam int IDX_WARM = NUM_RAMS;
  localparam int IDX_TAP = NUM_RAMS + NUM_MODULES;
  localparam int IDX_DBG = IDX_TAP + 1;
  localparam int IDX_COLD = IDX_TAP + 2;
  localparam int IDX_CORE = IDX_TAP + 3;
  localparam int IDX_SEC = IDX_TAP + 4;

  logic [NUM_MODULES-1:0] maskReg;
  logic [NUM_RAMS-1:0] coldEnReg, warmEnReg;
  logic [CAUSE_W-1:0] causeReg;

  logic fullHold;
  logic [NUM_MODULES-1:0] rawWarm;
  logic [NUM_RAMS-1:0] rawRam;
  logic rawDbg, rawTap;
  logic [NUM_OUT-1:0] rawVec, stage1, stage2;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      maskReg <= '0;
      coldEnReg <= '1;
      warmEnReg <= '0;
      causeReg <= CAUSE_W'(1 << CAUSE_POR);
    end else begin
      if (regWrEn && regAddr == 2'd0) maskReg <= regWrData[NUM_MODULES-1:0];
      if (regWrEn && regAddr == 2'd1) coldEnReg <= regWrData[NUM_RAMS-1:0];
      if (regWrEn && regAddr == 2'd2) warmEnReg <= regWrData[NUM_RAMS-1:0];
      if (strobe.causeLoad) causeReg <= strobe.causeCode;
      else if (regWrEn && regAddr == 2'd3)
        causeReg <= causeReg & ~regWrData[CAUSE_W-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      2'd0: regRdData = DATA_W'(maskReg);
      2'd1: regRdData = DATA_W'(coldEnReg);
      2'd2: regRdData = DATA_W'(warmEnReg);
      default: regRdData = DATA_W'(causeReg);
    endcase
  end

  assign fullHold = strobe.fuseWait | strobe.coldHold;
  assign rawDbg = fullHold | strobe.dbgHold;
  assign rawTap = fullHold | strobe.tapHold;

  for (genvar i = 0; i < NUM_MODULES; i++) begin : g_warm
    assign rawWarm[i] = fullHold | (strobe.warmHold & (~maskReg[i] | UNMASKABLE[i]));
  end

  for (genvar j = 0; j < NUM_RAMS; j++) begin : g_ram
    assign rawRam[j] = (strobe.coldHold & coldEnReg[j]) |
                       (strobe.warmHold & warmEnReg[j] &
                        (~maskReg[RAM_BASE+j] | UNMASKABLE[RAM_BASE+j]));
  end

  assign rawVec = {1'b0, strobe.fuseWait, fullHold, rawDbg, rawTap, rawWarm, rawRam};

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_sync
    localparam logic RST_VAL = (k >= IDX_WARM);
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        stage1[k] <= RST_VAL;
        stage2[k] <= RST_VAL;
      end else begin
        stage1[k] <= rawVec[k];
        stage2[k] <= stage1[k];
      end
    end
  end

  assign ramClr = stage2[IDX_RAM +: NUM_RAMS];
  assign warmRst = stage2[IDX_WARM +: NUM_MODULES];
  assign tapRst = stage2[IDX_TAP];
  assign dbgRst = stage2[IDX_DBG];
  assign coldRst = stage2[IDX_COLD];
  assign coreRst = stage2[IDX_CORE];
  assign secRst = stage2[IDX_SEC];

  // R5: a warm hold never reaches the debug, TAP or cold domains
  p_warm_spares_debug_r5: assert property (@(posedge clk) disable iff (!porN)
    strobe.warmHold |-> (!rawDbg && !rawTap && !rawVec[IDX_COLD]));

  // R6: unmaskable modules are always hit by a warm hold
  p_unmaskable_r6: assert property (@(posedge clk) disable iff (!porN)
    strobe.warmHold |-> ((rawWarm & UNMASKABLE) == UNMASKABLE));

  // R12: at most one cause bit is ever set
  p_cause_onehot_r12: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(causeReg));

  // R3: once released, the security domain stays released
  p_sec_stays_released_r3: assert property (@(posedge clk) disable iff (!porN)
    !secRst |=> !secRst);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_sequencer_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int NUM_MODULES = 8,
  parameter int NUM_RAMS = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   fuseValid,
  input  logic                   coldReq,
  input  logic                   warmReq,
  input  logic                   debugReq,
  input  logic                   tapReq,
  input  logic                   fabricReq,
  input  logic                   fabricConfigured,
  input  logic                   regWrEn,
  input  logic [1:0]             regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   secRst,
  output logic                   coreRst,
  output logic                   coldRst,
  output logic [NUM_MODULES-1:0] warmRst,
  output logic                   dbgRst,
  output logic                   tapRst,
  output logic [NUM_RAMS-1:0]    ramClr
);

  seqStrobe_t strobe;

  reset_sequencer_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk(clk), .porN(porN), .fuseValid(fuseValid),
    .coldReq(coldReq), .warmReq(warmReq), .debugReq(debugReq),
    .tapReq(tapReq), .fabricReq(fabricReq),
    .fabricConfigured(fabricConfigured), .strobe(strobe)
  );

  reset_sequencer_datapath #(
    .NUM_MODULES(NUM_MODULES), .NUM_RAMS(NUM_RAMS), .DATA_W(DATA_W)
  ) datapath_i (
    .clk(clk), .porN(porN), .strobe(strobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .secRst(secRst), .coreRst(coreRst),
    .coldRst(coldRst), .warmRst(warmRst), .dbgRst(dbgRst),
    .tapRst(tapRst), .ramClr(ramClr)
  );

endmodule

// File: tb/reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module reset_sequencer_tb_top;

  localparam int HOLD = 16;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic fuseValid = 1'b0;
  logic coldReq = 1'b0, warmReq = 1'b0, debugReq = 1'b0, tapReq = 1'b0;
  logic fabricReq = 1'b0, fabricConfigured = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic secRst, coreRst, coldRst, dbgRst, tapRst;
  logic [7:0] warmRst;
  logic [3:0] ramClr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [16:0] ever;
  int cnt [17];
  int firstIdx;

  always #4 clk = ~clk;

  reset_sequencer dut_i (
    .clk(clk), .porN(porN), .fuseValid(fuseValid), .coldReq(coldReq),
    .warmReq(warmReq), .debugReq(debugReq), .tapReq(tapReq),
    .fabricReq(fabricReq), .fabricConfigured(fabricConfigured),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .secRst(secRst), .coreRst(coreRst),
    .coldRst(coldRst), .warmRst(warmRst), .dbgRst(dbgRst),
    .tapRst(tapRst), .ramClr(ramClr)
  );

  // bit 16 sec, 15 core, 14 cold, 13 dbg, 12 tap, 11:4 warm, 3:0 ram
  function automatic logic [16:0] outVec();
    return {secRst, coreRst, coldRst, dbgRst, tapRst, warmRst, ramClr};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // 0 cold, 1 warm, 2 debug, 3 tap, 4 fabric, 5 debug+tap
  task automatic pulse(input int kind);
    case (kind)
      0: coldReq = 1'b1;
      1: warmReq = 1'b1;
      2: debugReq = 1'b1;
      3: tapReq = 1'b1;
      4: fabricReq = 1'b1;
      default: begin debugReq = 1'b1; tapReq = 1'b1; end
    endcase
    @(negedge clk);
    coldReq = 1'b0; warmReq = 1'b0; debugReq = 1'b0;
    tapReq = 1'b0; fabricReq = 1'b0;
  endtask

  task automatic observe();
    logic [16:0] s;
    ever = '0;
    firstIdx = -1;
    for (int b = 0; b < 17; b++) cnt[b] = 0;
    for (int i = 0; i < WIN; i++) begin
      s = outVec();
      if (s != 0 && firstIdx < 0) firstIdx = i;
      ever |= s;
      for (int b = 0; b < 17; b++) if (s[b]) cnt[b]++;
      @(negedge clk);
    end
  endtask

  task automatic checkCounts(input logic [16:0] mask, input string req);
    for (int b = 0; b < 17; b++)
      if (mask[b]) chk(cnt[b] == HOLD, req, cnt[b], HOLD);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    porN = 1'b0;
    repeat (3) @(negedge clk);
    chk(outVec() == 17'h1FFF0, "R1 outputs under por", outVec(), 17'h1FFF0);
    regRead(2'd0, d); chk(d == 0, "R1 mask default", d, 0);
    regRead(2'd1, d); chk(d == 32'hF, "R1 cold enable default", d, 32'hF);
    regRead(2'd2, d); chk(d == 0, "R1 warm enable default", d, 0);
    regRead(2'd3, d); chk(d == 32'h1, "R12 cause after por", d, 1);
    @(negedge clk);
  endtask

  task automatic t_fuse_and_cold_seq();
    porN = 1'b1;
    repeat (3) @(negedge clk);
    chk(secRst == 1'b0, "R2 security released", secRst, 0);
    repeat (10) @(negedge clk);
    chk(outVec() == 17'h0FFF0, "R2 held while fuse pending", outVec(), 17'h0FFF0);
    fuseValid = 1'b1;
    @(negedge clk);
    observe();
    chk(ever[16] == 1'b0, "R3 security not re-asserted", ever[16], 0);
    chk(cnt[15] == 2, "R3 core release latency", cnt[15], 2);
    chk(cnt[14] == HOLD + 2, "R3 cold hold length", cnt[14], HOLD + 2);
    chk(cnt[13] == HOLD + 2, "R3 debug held in cold", cnt[13], HOLD + 2);
    chk(cnt[0] == HOLD, "R3 ram clear on cold", cnt[0], HOLD);
    chk(outVec() == 0, "R3 all released", outVec(), 0);
  endtask

  task automatic t_cold_req();
    logic [31:0] d;
    pulse(0);
    observe();
    chk(ever == 17'h07FFF, "R4 cold request domains", ever, 17'h07FFF);
    checkCounts(17'h07FFF, "R11 cold hold length");
    chk(firstIdx == 2, "R11 latency", firstIdx, 2);
    regRead(2'd3, d); chk(d == 32'h2, "R12 cause cold", d, 2);
  endtask

  task automatic t_warm_default();
    logic [31:0] d;
    pulse(1);
    observe();
    chk(ever == 17'h00FF0, "R5 warm only warm domains", ever, 17'h00FF0);
    checkCounts(17'h00FF0, "R11 warm hold length");
    regRead(2'd3, d); chk(d == 32'h4, "R12 cause warm", d, 4);
  endtask

  task automatic t_mask_and_ram();
    logic [31:0] d;
    regWrite(2'd0, 32'hFF);
    regWrite(2'd2, 32'hF);
    regRead(2'd0, d); chk(d == 32'hFF, "R6 mask readback", d, 32'hFF);
    pulse(1);
    observe();
    chk(ever == 17'h00030, "R6 unmaskable bits only", ever, 17'h00030);
    regWrite(2'd0, 32'h50);
    pulse(1);
    observe();
    chk(ever[11:4] == 8'hAF, "R6 partial mask", ever[11:4], 8'hAF);
    chk(ever[3:0] == 4'hA, "R10 selective ram clear", ever[3:0], 4'hA);
    checkCounts(17'h00AFA, "R11 masked warm length");
    regWrite(2'd2, 32'h0);
    regWrite(2'd0, 32'h0);
  endtask

  task automatic t_debug_tap();
    logic [31:0] d;
    pulse(2);
    observe();
    chk(ever == 17'h02000, "R7 debug only", ever, 17'h02000);
    chk(cnt[13] == HOLD, "R11 debug length", cnt[13], HOLD);
    regRead(2'd3, d); chk(d == 32'h8, "R7 cause debug", d, 8);
    pulse(3);
    observe();
    chk(ever == 17'h01000, "R8 tap only", ever, 17'h01000);
    regRead(2'd3, d); chk(d == 32'h10, "R12 cause tap", d, 16);
    pulse(5);
    observe();
    chk(ever == 17'h03000, "R8 debug and tap together", ever, 17'h03000);
    regRead(2'd3, d); chk(d == 32'h8, "R7 debug wins cause", d, 8);
  endtask

  task automatic t_fabric();
    logic [31:0] d;
    fabricConfigured = 1'b0;
    pulse(4);
    observe();
    chk(ever == 0, "R9 fabric ignored unconfigured", ever, 0);
    regRead(2'd3, d); chk(d == 32'h8, "R9 cause unchanged", d, 8);
    fabricConfigured = 1'b1;
    pulse(4);
    observe();
    chk(ever == 17'h00FF0, "R9 fabric acts as warm", ever, 17'h00FF0);
    regRead(2'd3, d); chk(d == 32'h20, "R12 cause fabric", d, 32'h20);
    fabricConfigured = 1'b0;
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    regWrite(2'd3, 32'h1);
    regRead(2'd3, d); chk(d == 32'h20, "R12 w1c other bit kept", d, 32'h20);
    regWrite(2'd3, 32'h20);
    regRead(2'd3, d); chk(d == 0, "R12 w1c clear", d, 0);
  endtask

  task automatic t_escalate();
    logic [31:0] d;
    pulse(1);
    repeat (4) @(negedge clk);
    pulse(0);
    observe();
    chk(ever[14] == 1'b1, "R4 cold escalates warm", ever[14], 1);
    chk(cnt[14] == HOLD, "R4 escalated cold length", cnt[14], HOLD);
    regRead(2'd3, d); chk(d == 32'h2, "R4 cause after escalation", d, 2);
  endtask

  task automatic t_ignore_in_hold();
    pulse(1);
    repeat (4) @(negedge clk);
    pulse(2);
    observe();
    chk(ever[13] == 1'b0, "R11 debug ignored during warm", ever[13], 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fuse_and_cold_seq();
    t_cold_req();
    t_warm_default();
    t_mask_and_ram();
    t_debug_tap();
    t_fabric();
    t_w1c();
    t_escalate();
    t_ignore_in_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule